// File: doc/BRIEF.md
# Hot-Plug Slot I/O Gating Controller

This block runs on the host side of one backplane slot. It decides when the host's drivers toward the slot may leave high impedance, and it asks the card's own power sequencer to shut down when the card is pulled. Three inputs come from the card: an active-low presence contact, the card's configuration-done flag and the power-good status of its regulators. The block treats all three as asynchronous and passes them through a multi-flop synchronizer before it uses them. The presence contact is also debounced.

Once the card is seen, the slot stays tri-stated for a programmable settle time. After that, the slot is driven only while the card reports both configuration done and power good. When the card leaves, the slot goes back to high impedance first. One cycle later the power-down line is pulled low, and it is then released as the controller returns to its empty state. The power-down output models an open-drain pin: a high level on `pdn_pull_low` means the line is pulled low, and a low level means it is released.

Top module: `slot_io_gate`

## Requirements
- R1: During and right after reset, `slot_hiz` is 1, `slot_ready` is 0 and `pdn_pull_low` is 0 (line released).
- R2: While `card_present_n` is high (no card), `slot_hiz` stays 1 and `slot_ready` stays 0, whatever the levels of `cfg_done` and `pwr_good`.
- R3: After the debounced presence goes active, the slot stays tri-stated for at least SETTLE_CYCLES clock cycles, even when `cfg_done` and `pwr_good` are already high.
- R4: After the settle time, the slot is driven (`slot_hiz`=0, `slot_ready`=1) only while both `cfg_done` and `pwr_good` are high. If either is low, the slot stays tri-stated.
- R5: If `cfg_done` or `pwr_good` drops while the slot is driven, `slot_hiz` returns to 1 and `slot_ready` to 0. When both return high, the slot is driven again without a new settle time.
- R6: On removal, `slot_hiz` is 1 for at least one cycle before `pdn_pull_low` rises, and `pdn_pull_low` is never 1 while the slot is driven.
- R7: A removal produces a power-down pulse of exactly two cycles, after which the line is released. A new insertion must then wait a full settle time again.
- R8: A presence pulse shorter than DEBOUNCE_CYCLES cycles has no effect: a driven slot stays driven and no power-down pulse appears.
- R9: A removal during the settle time also produces the two-cycle power-down pulse, and the slot is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present_n | input | 1 | Presence contact, low when a card is seated (asynchronous) |
| cfg_done | input | 1 | Configuration-done flag from the card (asynchronous) |
| pwr_good | input | 1 | Power-good status of the card regulators (asynchronous) |
| slot_hiz | output | 1 | 1 holds all slot signal drivers in high impedance |
| pdn_pull_low | output | 1 | 1 pulls the open-drain power-down line low, 0 releases it |
| slot_ready | output | 1 | 1 while the host may use the slot |

## Verification
The hardest cases to reach are short presence bounces and removals that arrive before the slot was ever driven. Both need the settle timer and the debouncer to be in particular states at the moment the contact changes. The stimulus gets there with a vector table that walks one insertion through settle, configuration and power-good drops. Directed sequences follow. One opens a presence gap shorter than the debounce window while the slot is active. Another pulls the card part-way through the settle time. During each removal the bench samples every cycle, so it can tell whether high impedance came before the power-down pulse and how long that pulse lasted.

// File: rtl/slotgate_pkg.sv
package slotgate_pkg;
   typedef enum logic [2:0] {
      ST_EMPTY    = 3'd0,
      ST_SETTLE   = 3'd1,
      ST_WAITCFG  = 3'd2,
      ST_ACTIVE   = 3'd3,
      ST_REMOVING = 3'd4
   } slot_state_t;
endpackage

// File: rtl/slotgate_sync.sv
module slotgate_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int SRW = STAGES * W;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slotgate_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("slotgate_sync: W must be at least 1");
      end
   endgenerate

   logic [SRW-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[SRW-W-1:0], d};
   end

   assign q = chain[SRW-1 -: W];
endmodule

// File: rtl/slotgate_debounce.sv
module slotgate_debounce #(
   parameter int   CYCLES  = 4,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (CYCLES < 0) begin : g_bad_cycles
         $error("slotgate_debounce: CYCLES must not be negative");
      end

      if (CYCLES == 0) begin : g_pass
         assign q = d;
      end else begin : g_filter
         localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
         localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

         logic [CW-1:0] cnt;
         logic          stable;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt    <= '0;
               stable <= RST_VAL;
            end else if (d == stable) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               cnt    <= '0;
               stable <= d;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign q = stable;

         // R8
         deb_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(stable) |-> $past(d != stable));
      end
   endgenerate
endmodule

// File: rtl/slotgate_timer.sv
module slotgate_timer #(
   parameter int CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic done
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("slotgate_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign done = en && (cnt == LAST);
endmodule

// File: rtl/slot_io_gate.sv
module slot_io_gate #(
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 16,
   parameter int SETTLE_CYCLES   = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic card_present_n,
   input  logic cfg_done,
   input  logic pwr_good,
   output logic slot_hiz,
   output logic pdn_pull_low,
   output logic slot_ready
);
   import slotgate_pkg::*;

   localparam int IN_W = 3;
   localparam logic [IN_W-1:0] IN_RST = 3'b001;

   logic [IN_W-1:0] raw_in, sync_in;
   logic            absent_s, cfg_s, pg_s, absent_d;
   logic            card_ok, settle_done;
   logic            pdn_q;
   slot_state_t     state, state_nx;

   assign raw_in = {pwr_good, cfg_done, card_present_n};

   slotgate_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
   );

   assign absent_s = sync_in[0];
   assign cfg_s    = sync_in[1];
   assign pg_s     = sync_in[2];
   assign card_ok  = cfg_s && pg_s;

   slotgate_debounce #(.CYCLES(DEBOUNCE_CYCLES), .RST_VAL(1'b1)) i_deb (
      .clk(clk), .rst_n(rst_n), .d(absent_s), .q(absent_d)
   );

   slotgate_timer #(.CYCLES(SETTLE_CYCLES)) i_settle (
      .clk(clk), .rst_n(rst_n), .en(state == ST_SETTLE), .done(settle_done)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_EMPTY:    if (!absent_d) state_nx = ST_SETTLE;
         ST_SETTLE:   if (absent_d) state_nx = ST_REMOVING;
                      else if (settle_done) state_nx = ST_WAITCFG;
         ST_WAITCFG:  if (absent_d) state_nx = ST_REMOVING;
                      else if (card_ok) state_nx = ST_ACTIVE;
         ST_ACTIVE:   if (absent_d) state_nx = ST_REMOVING;
                      else if (!card_ok) state_nx = ST_WAITCFG;
         ST_REMOVING: if (pdn_q) state_nx = ST_EMPTY;
         default:     state_nx = ST_EMPTY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_EMPTY;
         pdn_q <= 1'b0;
      end else begin
         state <= state_nx;
         pdn_q <= (state == ST_REMOVING);
      end
   end

   assign slot_hiz     = (state != ST_ACTIVE);
   assign slot_ready   = (state == ST_ACTIVE);
   assign pdn_pull_low = pdn_q;

   // R4
   drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_hiz |-> $past(card_ok && !absent_d));

   // R6
   pdn_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_pull_low |-> slot_hiz);

   // R6
   pdn_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdn_pull_low) |-> $past(slot_hiz));

   // R7
   pdn_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn_pull_low && $past(pdn_pull_low)) |=> !pdn_pull_low);
endmodule

// File: tb/test_slot_io_gate.sv
module test_slot_io_gate;
   localparam int SETTLE = 40;
   localparam int DEB    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic card_present_n = 1'b1;
   logic cfg_done = 1'b0;
   logic pwr_good = 1'b0;
   logic slot_hiz, pdn_pull_low, slot_ready;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   slot_io_gate #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(DEB), .SETTLE_CYCLES(SETTLE)) i_slot_io_gate (
      .clk(clk), .rst_n(rst_n), .card_present_n(card_present_n),
      .cfg_done(cfg_done), .pwr_good(pwr_good),
      .slot_hiz(slot_hiz), .pdn_pull_low(pdn_pull_low), .slot_ready(slot_ready)
   );

   // {present_n, cfg, pg, wait[7:0], exp_hiz, exp_ready}
   localparam logic [12:0] VEC [0:6] = '{
      {1'b1, 1'b1, 1'b1, 8'd20, 1'b1, 1'b0},
      {1'b0, 1'b1, 1'b1, 8'd25, 1'b1, 1'b0},
      {1'b0, 1'b1, 1'b1, 8'd40, 1'b0, 1'b1},
      {1'b0, 1'b0, 1'b1, 8'd10, 1'b1, 1'b0},
      {1'b0, 1'b1, 1'b1, 8'd10, 1'b0, 1'b1},
      {1'b0, 1'b1, 1'b0, 8'd10, 1'b1, 1'b0},
      {1'b0, 1'b1, 1'b1, 8'd10, 1'b0, 1'b1}
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic watch(input int cycles, output int t_hiz, output int t_pdn,
                        output int n_pdn, output int n_bad);
      t_hiz = -1; t_pdn = -1; n_pdn = 0; n_bad = 0;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         if (slot_hiz && t_hiz < 0) t_hiz = c;
         if (pdn_pull_low) begin
            n_pdn++;
            if (t_pdn < 0) t_pdn = c;
            if (!slot_hiz) n_bad++;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int th, tp, np, nb;
      // R1 during and after reset
      repeat (3) @(negedge clk);
      chk("R1 hiz in reset", slot_hiz, 1'b1);
      chk("R1 ready in reset", slot_ready, 1'b0);
      chk("R1 pdn in reset", pdn_pull_low, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 hiz after reset", slot_hiz, 1'b1);
      chk("R1 pdn after reset", pdn_pull_low, 1'b0);

      // Vector table: R2 R3 R4 R5
      for (int i = 0; i < 7; i++) begin
         card_present_n = VEC[i][12];
         cfg_done       = VEC[i][11];
         pwr_good       = VEC[i][10];
         repeat (int'(VEC[i][9:2])) @(negedge clk);
         chk($sformatf("R2 R3 R4 R5 row %0d hiz", i), slot_hiz, VEC[i][1]);
         chk($sformatf("R2 R3 R4 R5 row %0d ready", i), slot_ready, VEC[i][0]);
      end

      // R8 short presence glitch while active
      card_present_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      card_present_n = 1'b0;
      watch(20, th, tp, np, nb);
      chk_int("R8 no pdn on glitch", np, 0);
      chk("R8 still driven", slot_hiz, 1'b0);
      chk("R8 still ready", slot_ready, 1'b1);

      // R6 R7 removal from active
      card_present_n = 1'b1;
      watch(30, th, tp, np, nb);
      chk("R6 hiz seen", th >= 0, 1'b1);
      chk("R6 hiz before pdn", (th >= 0) && (tp > th), 1'b1);
      chk_int("R6 pdn while driven", nb, 0);
      chk_int("R7 pdn pulse length", np, 2);
      chk("R7 pdn released", pdn_pull_low, 1'b0);
      chk("R7 hiz after removal", slot_hiz, 1'b1);

      // R7 reinsertion needs a full settle again
      card_present_n = 1'b0;
      repeat (25) @(negedge clk);
      chk("R7 R3 settle on reinsertion", slot_hiz, 1'b1);
      repeat (40) @(negedge clk);
      chk("R7 driven after settle", slot_hiz, 1'b0);

      // R9 removal during settle
      card_present_n = 1'b1;
      repeat (30) @(negedge clk);
      card_present_n = 1'b0;
      repeat (20) @(negedge clk);
      card_present_n = 1'b1;
      watch(30, th, tp, np, nb);
      chk_int("R9 pdn pulse in settle", np, 2);
      chk_int("R9 never driven", nb, 0);
      chk("R9 hiz at start", th == 0, 1'b1);
      chk("R9 released", pdn_pull_low, 1'b0);

      // R2 absent card with card flags high
      repeat (10) @(negedge clk);
      chk("R2 absent hiz", slot_hiz, 1'b1);
      chk("R2 absent ready", slot_ready, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule